// File: doc/BRIEF.md
# DisplayPort link training sequencer

This block runs the two-phase bring-up of a DisplayPort main link. When started, it reads the sink's capability bytes over a single-byte request/acknowledge port that stands in for the AUX channel. It then refuses any link it cannot support. If the sink is new enough, it wakes the sink to its active power state. It programs the link rate and lane count, and then runs clock recovery followed by channel equalization. Each training iteration presents the current drive setting to the local transmitter, waits a settling delay counted in clock cycles, reads the six-byte lane status block, and either finishes or derives the next drive setting from the sink's adjustment requests.

The result is reported through a start/done/fail handshake. `done_o` and `fail_o` are held until the next start. The analog transmitter and the training symbol generation sit outside the block. They see only `pattern_o`, `drive_o`, `link_rate_o` and `lane_cnt_o`.

Top module: `lt_train_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o`, `aux_req_o` and `pattern_o` are 0, `drive_o` is all zero, and a start in idle makes `busy_o` 1 and clears `done_o` and `fail_o`.
- R2: A run begins with reads of sink addresses 0x000 (revision), 0x001 (rate code) and 0x002 (lane count), in that order. The lane count is bits [4:0] of the third byte.
- R3: A run is refused when the rate code is neither 0x06 nor 0x0A, or when the lane count is 0. A refused run ends with `done_o`=1 and `fail_o`=1 after exactly those three reads.
- R4: When the revision is 0x11 or more, the block reads address 0x600 and writes back the byte with bits [1:0] replaced by 01. It issues no further request for at least PWR_WAIT_US microseconds. A lower revision never touches 0x600.
- R5: The rate code is written to 0x100 and the masked lane count to 0x101. Both are then presented on `link_rate_o` and `lane_cnt_o`.
- R6: Clock recovery sets `pattern_o`=1 and writes 0x01 to 0x102. It starts from drive byte 0. Each iteration writes the drive byte to 0x103+l for every active lane l, waits at least CR_WAIT_US, and reads status bytes 0x202..0x207.
- R7: Clock recovery succeeds when bit 0 of every active lane's status nibble is set. Lane l's nibble lives in byte 0x202+l/2, at bit 4*(l mod 2). Inactive lanes are ignored both here and in R8.
- R8: The next drive byte is built from the adjust bytes 0x206+l/2. Lane l's swing sits at bits [4*(l mod 2)+1 : 4*(l mod 2)] and its pre-emphasis two bits above that. The drive byte holds the maximum swing over active lanes in [1:0], a flag in bit 2 when that swing is 3, the maximum pre-emphasis in [4:3], and a flag in bit 5 when that value is 3. The same byte drives every lane.
- R9: Clock recovery fails when the status misses R7 while the current drive byte already carries the max-swing flag.
- R10: A counter increments when the lane-0 swing of the current drive byte equals that of the previous iteration, and clears otherwise. Clock recovery fails when the counter reaches CR_MAX_TRIES. With the defaults, that is on the sixth status read.
- R11: Equalization sets `pattern_o`=2 and writes 0x02 to 0x102. Each iteration waits at least EQ_WAIT_US and reads the status block, with no lane drive writes to the sink. It passes when bit 0 of 0x204 is set and every active lane nibble has bits [2:0] all set.
- R12: Equalization fails after EQ_MAX_TRIES status reads without a pass. Between reads, the drive byte is updated per R8.
- R13: A transaction acknowledged with `aux_err_i` ends the run at once with `done_o`=1 and `fail_o`=1, and no further request is issued.
- R14: A request holds its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a training run (taken only when idle) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run finished, held until next start |
| fail_o | output | 1 | Last run failed, valid with done_o |
| aux_req_o | output | 1 | Sink access request, held until acknowledged |
| aux_we_o | output | 1 | 1 = write, 0 = read |
| aux_addr_o | output | AW | Sink register address |
| aux_wdata_o | output | 8 | Write byte |
| aux_ack_i | input | 1 | Access completed this cycle |
| aux_err_i | input | 1 | Access failed, valid with aux_ack_i |
| aux_rdata_i | input | 8 | Read byte, valid with aux_ack_i |
| pattern_o | output | 2 | Training pattern selected for the transmitter |
| drive_o | output | 8*MAX_LANES | Drive byte per lane, lane 0 in the low byte |
| link_rate_o | output | 8 | Programmed link rate code |
| lane_cnt_o | output | 5 | Programmed lane count |

## Verification
The hardest state to reach is the clock-recovery give-up on repeated swing. It needs a sink that keeps requesting the same level for six full iterations. A variant of that case must also hide a max-swing request on an inactive lane, so that only correct lane masking picks the repeat rule over the max-swing rule. The bench's sink model computes the status bytes from the drive byte last written to lane 0 and from a per-scenario threshold. It also counts equalization reads against a second threshold. Each scenario therefore walks a chosen path, and the number of status reads tells the paths apart. The sink also acknowledges one cycle late, so request stability is observed.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_CAP, S_CHK, S_PWR_RD, S_PWR_WR, S_PWR_WAIT, S_BW_WR, S_LC_WR,
    S_CR_PAT, S_CR_LANE, S_CR_WAIT, S_CR_STAT, S_CR_EVAL,
    S_EQ_PAT, S_EQ_WAIT, S_EQ_STAT, S_EQ_EVAL
  } lt_state_e;

  localparam logic [11:0] A_LINK_BW  = 12'h100;
  localparam logic [11:0] A_LANE_CNT = 12'h101;
  localparam logic [11:0] A_PATTERN  = 12'h102;
  localparam logic [11:0] A_LANE_SET = 12'h103;
  localparam logic [11:0] A_STATUS   = 12'h202;
  localparam logic [11:0] A_POWER    = 12'h600;

  localparam logic [7:0] RATE_LOW  = 8'h06;
  localparam logic [7:0] RATE_HIGH = 8'h0A;
  localparam logic [7:0] REV_PWR   = 8'h11;
  localparam int unsigned STAT_N   = 6;
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cycles_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= cycles_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0) && !load_i;

  assert_timer_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lt_status_eval.sv
module lt_status_eval #(
  parameter int unsigned MAX_LANES = 4,
  parameter int unsigned STAT_N    = 6,
  localparam int unsigned LCW      = $clog2(MAX_LANES + 1)
) (
  input  logic [STAT_N*8-1:0] stat_i,
  input  logic [LCW-1:0]      lanes_i,
  output logic                cr_ok_o,
  output logic                eq_ok_o,
  output logic [7:0]          adj_o
);
  logic [MAX_LANES-1:0] lane_cr, lane_eq;
  logic [1:0]           sw [MAX_LANES];
  logic [1:0]           pe [MAX_LANES];

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    logic       act;
    logic [3:0] nib, req;
    assign act        = LCW'(l) < lanes_i;
    assign nib        = stat_i[(l/2)*8 + 4*(l%2) +: 4];
    assign req        = stat_i[(4 + l/2)*8 + 4*(l%2) +: 4];
    assign lane_cr[l] = !act || nib[0];
    assign lane_eq[l] = !act || (&nib[2:0]);
    assign sw[l]      = act ? req[1:0] : 2'd0;
    assign pe[l]      = act ? req[3:2] : 2'd0;
  end

  logic [1:0] v, p;
  always_comb begin
    v = 2'd0;
    p = 2'd0;
    for (int l = 0; l < MAX_LANES; l++) begin
      if (sw[l] > v) v = sw[l];
      if (pe[l] > p) p = pe[l];
    end
    adj_o = {2'b00, p == 2'd3, p, v == 2'd3, v};
  end

  assign cr_ok_o = &lane_cr;
  assign eq_ok_o = (&lane_eq) && stat_i[16];
endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
  import lt_pkg::*;
#(
  parameter int unsigned MAX_LANES    = 4,
  parameter int unsigned AW           = 20,
  parameter int unsigned CYC_PER_US   = 250,
  parameter int unsigned CR_WAIT_US   = 1000,
  parameter int unsigned EQ_WAIT_US   = 400,
  parameter int unsigned PWR_WAIT_US  = 1000,
  parameter int unsigned CR_MAX_TRIES = 5,
  parameter int unsigned EQ_MAX_TRIES = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   fail_o,
  output logic                   aux_req_o,
  output logic                   aux_we_o,
  output logic [AW-1:0]          aux_addr_o,
  output logic [7:0]             aux_wdata_o,
  input  logic                   aux_ack_i,
  input  logic                   aux_err_i,
  input  logic [7:0]             aux_rdata_i,
  output logic [1:0]             pattern_o,
  output logic [8*MAX_LANES-1:0] drive_o,
  output logic [7:0]             link_rate_o,
  output logic [4:0]             lane_cnt_o
);
  localparam int unsigned LCW     = $clog2(MAX_LANES + 1);
  localparam int unsigned CR_CYC  = CR_WAIT_US * CYC_PER_US;
  localparam int unsigned EQ_CYC  = EQ_WAIT_US * CYC_PER_US;
  localparam int unsigned PWR_CYC = PWR_WAIT_US * CYC_PER_US;
  localparam int unsigned MAX_CYC = (CR_CYC > PWR_CYC) ? ((CR_CYC > EQ_CYC) ? CR_CYC : EQ_CYC)
                                                       : ((PWR_CYC > EQ_CYC) ? PWR_CYC : EQ_CYC);
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);
  localparam int unsigned MT      = (CR_MAX_TRIES > EQ_MAX_TRIES) ? CR_MAX_TRIES : EQ_MAX_TRIES;
  localparam int unsigned TRW     = $clog2(MT + 1);

  lt_state_e           state_q;
  logic [2:0]          idx_q;
  logic [7:0]          rev_q, rate_q, pwr_q, ts_q;
  logic [4:0]          lanes_q;
  logic [STAT_N*8-1:0] stat_q;
  logic [1:0]          prev_sw_q, pat_q;
  logic                prev_vld_q, done_q, fail_q, load_q;
  logic [TRW-1:0]      tries_q;
  logic [TW-1:0]       tmr_cyc_q;
  logic [7:0]          rate_out_q;
  logic [4:0]          lanes_out_q;
  logic [LCW-1:0]      act;
  logic                xfer, bad, expired, cr_ok, eq_ok, same_sw, rate_ok;
  logic [7:0]          adj;

  assign act = (lanes_q > 5'(MAX_LANES)) ? LCW'(MAX_LANES) : LCW'(lanes_q);

  lt_wait_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(load_q), .cycles_i(tmr_cyc_q), .expired_o(expired)
  );

  lt_status_eval #(.MAX_LANES(MAX_LANES), .STAT_N(STAT_N)) u_eval (
    .stat_i(stat_q), .lanes_i(act), .cr_ok_o(cr_ok), .eq_ok_o(eq_ok), .adj_o(adj)
  );

  // sink access decode
  always_comb begin
    aux_req_o   = 1'b0;
    aux_we_o    = 1'b0;
    aux_addr_o  = '0;
    aux_wdata_o = '0;
    unique case (state_q)
      S_CAP:    begin aux_req_o = 1'b1; aux_addr_o = AW'(idx_q); end
      S_PWR_RD: begin aux_req_o = 1'b1; aux_addr_o = AW'(A_POWER); end
      S_PWR_WR: begin aux_req_o = 1'b1; aux_we_o = 1'b1; aux_addr_o = AW'(A_POWER);
                      aux_wdata_o = {pwr_q[7:2], 2'b01}; end
      S_BW_WR:  begin aux_req_o = 1'b1; aux_we_o = 1'b1; aux_addr_o = AW'(A_LINK_BW);
                      aux_wdata_o = rate_q; end
      S_LC_WR:  begin aux_req_o = 1'b1; aux_we_o = 1'b1; aux_addr_o = AW'(A_LANE_CNT);
                      aux_wdata_o = {3'b000, lanes_q}; end
      S_CR_PAT: begin aux_req_o = 1'b1; aux_we_o = 1'b1; aux_addr_o = AW'(A_PATTERN);
                      aux_wdata_o = 8'h01; end
      S_EQ_PAT: begin aux_req_o = 1'b1; aux_we_o = 1'b1; aux_addr_o = AW'(A_PATTERN);
                      aux_wdata_o = 8'h02; end
      S_CR_LANE: begin aux_req_o = 1'b1; aux_we_o = 1'b1;
                      aux_addr_o = AW'(A_LANE_SET) + AW'(idx_q); aux_wdata_o = ts_q; end
      S_CR_STAT, S_EQ_STAT: begin aux_req_o = 1'b1; aux_addr_o = AW'(A_STATUS) + AW'(idx_q); end
      default: ;
    endcase
  end

  assign xfer    = aux_req_o && aux_ack_i;
  assign bad     = xfer && aux_err_i;
  assign same_sw = prev_vld_q && (ts_q[1:0] == prev_sw_q);
  assign rate_ok = (rate_q == RATE_LOW) || (rate_q == RATE_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;   idx_q <= '0;      rev_q <= '0;      rate_q <= '0;
      pwr_q <= '0;         ts_q <= '0;       lanes_q <= '0;    stat_q <= '0;
      prev_sw_q <= '0;     pat_q <= '0;      prev_vld_q <= 1'b0;
      done_q <= 1'b0;      fail_q <= 1'b0;   load_q <= 1'b0;   tries_q <= '0;
      tmr_cyc_q <= '0;     rate_out_q <= '0; lanes_out_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (bad) begin
        state_q <= S_IDLE; done_q <= 1'b1; fail_q <= 1'b1;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            done_q <= 1'b0; fail_q <= 1'b0; idx_q <= '0; pat_q <= '0; ts_q <= '0;
            state_q <= S_CAP;
          end
          S_CAP: if (xfer) begin
            case (idx_q)
              3'd0:    rev_q   <= aux_rdata_i;
              3'd1:    rate_q  <= aux_rdata_i;
              default: lanes_q <= aux_rdata_i[4:0];
            endcase
            idx_q <= idx_q + 1'b1;
            if (idx_q == 3'd2) state_q <= S_CHK;
          end
          S_CHK:
            if (!rate_ok || lanes_q == '0) begin
              state_q <= S_IDLE; done_q <= 1'b1; fail_q <= 1'b1;
            end else state_q <= (rev_q >= REV_PWR) ? S_PWR_RD : S_BW_WR;
          S_PWR_RD: if (xfer) begin pwr_q <= aux_rdata_i; state_q <= S_PWR_WR; end
          S_PWR_WR: if (xfer) begin
            load_q <= 1'b1; tmr_cyc_q <= TW'(PWR_CYC); state_q <= S_PWR_WAIT;
          end
          S_PWR_WAIT: if (expired) state_q <= S_BW_WR;
          S_BW_WR: if (xfer) begin rate_out_q <= rate_q; state_q <= S_LC_WR; end
          S_LC_WR: if (xfer) begin
            lanes_out_q <= lanes_q; pat_q <= 2'd1; ts_q <= '0;
            tries_q <= '0; prev_vld_q <= 1'b0; state_q <= S_CR_PAT;
          end
          S_CR_PAT: if (xfer) begin idx_q <= '0; state_q <= S_CR_LANE; end
          S_CR_LANE: if (xfer) begin
            if (idx_q == 3'(act - 1'b1)) begin
              load_q <= 1'b1; tmr_cyc_q <= TW'(CR_CYC); state_q <= S_CR_WAIT;
            end else idx_q <= idx_q + 1'b1;
          end
          S_CR_WAIT: if (expired) begin idx_q <= '0; state_q <= S_CR_STAT; end
          S_CR_STAT, S_EQ_STAT: if (xfer) begin
            stat_q[idx_q*8 +: 8] <= aux_rdata_i;
            idx_q <= idx_q + 1'b1;
            if (idx_q == 3'(STAT_N - 1))
              state_q <= (state_q == S_CR_STAT) ? S_CR_EVAL : S_EQ_EVAL;
          end
          S_CR_EVAL:
            if (cr_ok) begin
              pat_q <= 2'd2; tries_q <= '0; state_q <= S_EQ_PAT;
            end else if (ts_q[2] || (same_sw && tries_q == TRW'(CR_MAX_TRIES - 1))) begin
              state_q <= S_IDLE; done_q <= 1'b1; fail_q <= 1'b1;
            end else begin
              tries_q    <= same_sw ? tries_q + 1'b1 : '0;
              prev_sw_q  <= ts_q[1:0];
              prev_vld_q <= 1'b1;
              ts_q       <= adj;
              idx_q      <= '0;
              state_q    <= S_CR_LANE;
            end
          S_EQ_PAT: if (xfer) begin
            load_q <= 1'b1; tmr_cyc_q <= TW'(EQ_CYC); state_q <= S_EQ_WAIT;
          end
          S_EQ_WAIT: if (expired) begin idx_q <= '0; state_q <= S_EQ_STAT; end
          S_EQ_EVAL:
            if (eq_ok) begin
              state_q <= S_IDLE; done_q <= 1'b1;
            end else if (tries_q == TRW'(EQ_MAX_TRIES - 1)) begin
              state_q <= S_IDLE; done_q <= 1'b1; fail_q <= 1'b1;
            end else begin
              tries_q <= tries_q + 1'b1; ts_q <= adj;
              load_q <= 1'b1; tmr_cyc_q <= TW'(EQ_CYC); state_q <= S_EQ_WAIT;
            end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign pattern_o   = pat_q;
  assign drive_o     = {MAX_LANES{ts_q}};
  assign link_rate_o = rate_out_q;
  assign lane_cnt_o  = lanes_out_q;

  assert_req_stable_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_req_o && !aux_ack_i) |=> (aux_req_o && $stable(aux_addr_o) &&
                                   $stable(aux_we_o) && $stable(aux_wdata_o)));

  assert_err_ends_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_req_o && aux_ack_i && aux_err_i) |=> (!aux_req_o && done_o && fail_o));

  assert_eq_no_lane_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pattern_o == 2'd2 && aux_req_o && aux_we_o) |->
      (aux_addr_o < AW'(A_LANE_SET) || aux_addr_o >= AW'(A_LANE_SET) + AW'(MAX_LANES)));

  assert_done_after_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_cr_pattern_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_req_o && aux_we_o && aux_addr_o >= AW'(A_LANE_SET) &&
     aux_addr_o < AW'(A_LANE_SET) + AW'(MAX_LANES)) |-> (pattern_o == 2'd1));
endmodule

// File: tb/sim_lt_train_seq.sv
module sim_lt_train_seq;
  localparam int CR_CYC = 1000;
  localparam int EQ_CYC = 400;
  localparam int PWR_CYC = 1000;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, fail_o, aux_req_o, aux_we_o;
  logic [19:0] aux_addr_o;
  logic [7:0] aux_wdata_o, aux_rdata_i = '0;
  logic aux_ack_i = 1'b0, aux_err_i = 1'b0;
  logic [1:0] pattern_o;
  logic [31:0] drive_o;
  logic [7:0] link_rate_o;
  logic [4:0] lane_cnt_o;

  always #2 clk = ~clk;

  lt_train_seq #(.CYC_PER_US(1)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .busy_o, .done_o, .fail_o,
    .aux_req_o, .aux_we_o, .aux_addr_o, .aux_wdata_o, .aux_ack_i, .aux_err_i,
    .aux_rdata_i, .pattern_o, .drive_o, .link_rate_o, .lane_cnt_o
  );

  typedef struct packed {
    logic [7:0]  rev, rate, lanes;
    logic [2:0]  cr_need;
    logic [7:0]  adj0, adj1, eq_need;
    logic [11:0] err_addr;
    logic        exp_fail;
    logic [7:0]  exp_reads;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{8'h12, 8'h0A, 8'h84, 3'd0, 8'h00, 8'h00, 8'd1,   12'hFFF, 1'b0, 8'd2},
    '{8'h12, 8'h14, 8'h04, 3'd0, 8'h00, 8'h00, 8'd1,   12'hFFF, 1'b1, 8'd0},
    '{8'h12, 8'h0A, 8'h80, 3'd0, 8'h00, 8'h00, 8'd1,   12'hFFF, 1'b1, 8'd0},
    '{8'h12, 8'h0A, 8'h04, 3'd2, 8'h22, 8'h22, 8'd1,   12'hFFF, 1'b0, 8'd3},
    '{8'h12, 8'h0A, 8'h04, 3'd4, 8'h00, 8'h00, 8'd1,   12'hFFF, 1'b1, 8'd6},
    '{8'h12, 8'h0A, 8'h04, 3'd4, 8'h03, 8'h00, 8'd1,   12'hFFF, 1'b1, 8'd2},
    '{8'h12, 8'h0A, 8'h04, 3'd0, 8'h00, 8'h00, 8'd255, 12'hFFF, 1'b1, 8'd6},
    '{8'h12, 8'h0A, 8'h02, 3'd0, 8'h00, 8'h00, 8'd3,   12'hFFF, 1'b0, 8'd4},
    '{8'h12, 8'h0A, 8'h04, 3'd0, 8'h00, 8'h00, 8'd1,   12'h204, 1'b1, 8'd1},
    '{8'h12, 8'h06, 8'h01, 3'd4, 8'h30, 8'h00, 8'd1,   12'hFFF, 1'b1, 8'd6},
    '{8'h10, 8'h0A, 8'h04, 3'd0, 8'h00, 8'h00, 8'd1,   12'hFFF, 1'b0, 8'd2},
    '{8'h12, 8'h0A, 8'h04, 3'd1, 8'h0D, 8'h00, 8'd1,   12'hFFF, 1'b0, 8'd3}
  };

  function automatic string tag(int i);
    case (i)
      0: tag = "R7"; 1: tag = "R3"; 2: tag = "R3"; 3: tag = "R8";
      4: tag = "R10"; 5: tag = "R9"; 6: tag = "R12"; 7: tag = "R11";
      8: tag = "R13"; 9: tag = "R10"; 10: tag = "R4"; default: tag = "R8";
    endcase
  endfunction

  int errors = 0, checks = 0, cyc = 0;
  bit timeout = 1'b0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sink model
  logic [7:0] mem [4096];
  logic [2:0] cr_need;
  logic [7:0] eq_need;
  logic [11:0] err_addr;
  int eq_cnt, n_stat, n_txn, n_pwr, n_eq_lane, unstable, gap_bad, after_err, last_cyc;
  bit err_seen, prev_pwr_wr, phase;
  logic [11:0] cap_addr [3];
  logic [19:0] l_addr;
  logic l_we;
  logic [7:0] l_wd;

  function automatic logic [7:0] rd_byte(logic [11:0] a);
    logic hit;
    hit = eq_cnt >= int'(eq_need);
    case (a)
      12'h202, 12'h203:
        if (mem[12'h102] == 8'h01) rd_byte = ({1'b0, mem[12'h103][1:0]} >= cr_need) ? 8'h11 : 8'h00;
        else rd_byte = hit ? 8'h77 : 8'h11;
      12'h204: rd_byte = (mem[12'h102] == 8'h02 && hit) ? 8'h01 : 8'h00;
      default: rd_byte = mem[a];
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) timeout = 1'b1;
    if (aux_ack_i) begin
      aux_ack_i <= 1'b0; aux_err_i <= 1'b0; phase = 1'b0;
    end else if (aux_req_o) begin
      if (!phase) begin
        l_addr = aux_addr_o; l_we = aux_we_o; l_wd = aux_wdata_o; phase = 1'b1;
      end else begin
        logic [11:0] a;
        a = aux_addr_o[11:0];
        if (l_addr != aux_addr_o || l_we != aux_we_o || l_wd != aux_wdata_o) unstable++;
        if (err_seen) after_err++;
        if (n_txn < 3) cap_addr[n_txn] = a;
        if (prev_pwr_wr && (cyc - last_cyc) < PWR_CYC) gap_bad++;
        if (a == 12'h600) n_pwr++;
        if (aux_we_o && mem[12'h102] == 8'h02 && a >= 12'h103 && a <= 12'h106) n_eq_lane++;
        if (!aux_we_o && a == 12'h202) begin
          n_stat++;
          if (mem[12'h102] == 8'h01 && (cyc - last_cyc) < CR_CYC) gap_bad++;
          if (mem[12'h102] == 8'h02) begin
            eq_cnt++;
            if ((cyc - last_cyc) < EQ_CYC) gap_bad++;
          end
        end
        prev_pwr_wr = aux_we_o && a == 12'h600;
        n_txn++;
        last_cyc = cyc;
        if (a == err_addr) begin
          aux_err_i <= 1'b1; err_seen = 1'b1;
        end else if (aux_we_o) mem[a] = aux_wdata_o;
        else aux_rdata_i <= rd_byte(a);
        aux_ack_i <= 1'b1;
      end
    end
  end

  task automatic run(int i);
    vec_t v;
    v = VT[i];
    for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
    mem[0] = v.rev; mem[1] = v.rate; mem[2] = v.lanes;
    mem[12'h600] = 8'h06; mem[12'h206] = v.adj0; mem[12'h207] = v.adj1;
    cr_need = v.cr_need; eq_need = v.eq_need; err_addr = v.err_addr;
    eq_cnt = 0; n_stat = 0; n_txn = 0; n_pwr = 0; n_eq_lane = 0; unstable = 0;
    gap_bad = 0; after_err = 0; err_seen = 1'b0; prev_pwr_wr = 1'b0; last_cyc = cyc;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && done_o === 1'b0, "R1", {busy_o, done_o}, 2'b10);
    while (!done_o && !timeout) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_o === 1'b1 && fail_o === v.exp_fail, tag(i), fail_o, v.exp_fail);
    chk(n_stat == int'(v.exp_reads), tag(i), n_stat, v.exp_reads);
    chk(gap_bad == 0, "R6", gap_bad, 0);
    chk(unstable == 0, "R14", unstable, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o === 0 && done_o === 0 && fail_o === 0 && aux_req_o === 0 &&
        pattern_o === 0 && drive_o === 0, "R1", {busy_o, done_o, fail_o, aux_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o === 0 && done_o === 0, "R1", {busy_o, done_o}, 0);
    for (int i = 0; i < NV; i++) begin
      if (!timeout) run(i);
      case (i)
        0: begin
          chk(cap_addr[0] == 0 && cap_addr[1] == 1 && cap_addr[2] == 2, "R2",
              {cap_addr[0], cap_addr[1], cap_addr[2]}, 36'h000001002);
          chk(mem[12'h600] == 8'h05, "R4", mem[12'h600], 8'h05);
          chk(mem[12'h100] == 8'h0A && mem[12'h101] == 8'h04, "R5",
              {mem[12'h100], mem[12'h101]}, 16'h0A04);
          chk(link_rate_o == 8'h0A && lane_cnt_o == 5'd4, "R5", {link_rate_o, lane_cnt_o}, 13'h144);
          chk(pattern_o == 2'd2 && mem[12'h102] == 8'h02, "R11", pattern_o, 2);
        end
        1, 2: chk(n_txn == 3, "R3", n_txn, 3);
        3: chk(drive_o == 32'h02020202, "R8", drive_o, 32'h02020202);
        4: chk(pattern_o == 2'd1 && mem[12'h102] == 8'h01 && mem[12'h106] == 8'h00, "R6",
               pattern_o, 1);
        7: chk(n_eq_lane == 0, "R11", n_eq_lane, 0);
        8: chk(after_err == 0, "R13", after_err, 0);
        9: chk(mem[12'h104] == 8'h00 && link_rate_o == 8'h06, "R7", mem[12'h104], 0);
        10: chk(n_pwr == 0, "R4", n_pwr, 0);
        11: chk(drive_o == 32'h39393939, "R8", drive_o, 32'h39393939);
        default: ;
      endcase
    end
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule